// File: doc/BRIEF.md
# Sticky Interrupt Register Bank

This block collects interrupt events for a serial bus controller and gives software a small register view of them. Peripheral logic raises single-cycle pulses on a ten-position event vector. Seven positions are live sources: transfer done, fresh receive data, missing acknowledge, target ready, receive overflow, transmit overflow and receive underflow. Each live source owns a sticky pending bit. Pending bits stay set until software clears them by writing ones.

Every source can be enabled or disabled. The enable state is never written directly. Software sets enable bits through one write-one register and clears them through another. The state is read back inverted, as a mask, through a separate read-only register. A single level interrupt line goes high while any source is both pending and enabled. The line follows the registers, so it moves in the cycle after any write that changes them.

Top module: `irqbank_top`

## Requirements
- R1: An event pulse on a live position (0 done, 1 new data, 2 no-ack, 4 target ready, 5 rx overflow, 6 tx overflow, 7 rx underflow) sets that pending bit at the next clock edge. This happens whether or not the source is enabled.
- R2: Writing to offset 0x10 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value. Reading 0x10 returns the pending bits at their positions.
- R3: If an event and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R4: Writing to offset 0x24 enables each live source whose data bit is 1. Zero bits leave the enable state unchanged.
- R5: Writing to offset 0x28 disables each live source whose data bit is 1. Zero bits leave the enable state unchanged.
- R6: Offset 0x20 reads 1 at each live position whose source is disabled and 0 where it is enabled. Writes to 0x20 change nothing.
- R7: Offsets 0x24 and 0x28 read as zero. Every other unmapped offset also reads as zero.
- R8: The interrupt output is high exactly when some live source is both pending and enabled. It reflects a write in the cycle after that write.
- R9: After reset no bit is pending and every source is disabled. The mask therefore reads 0x0F7 and the interrupt output is low.
- R10: Positions 3, 8 and 9, and bits 31:10, always read 0 in the pending and mask registers. Events and writes on those positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_i | input | 10 | Single-cycle event pulses, one per bit position |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational from the register state |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench fires an event in the same cycle as a clear of the same bit. A design that lets the clear win would lose that interrupt, and the bench would see the pending bit read back as 0.

It writes zeros to the status, enable and disable registers. A design that treats these registers as plain storage instead of write-one actions would wipe or alter state, and the readback would show it.

It drives events and writes on the reserved positions and writes to the read-only mask. A design that stores any of these would show stray ones in the readback.

A long random phase mixes events, writes and reads against a behavioural model. This catches an interrupt line that lags by a cycle or ignores its enable.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int VEC_W  = 10;
  localparam int ADDR_W = 6;
  localparam logic [VEC_W-1:0] LIVE_BITS = 10'b00_1111_0111;

  localparam logic [ADDR_W-1:0] OFF_PEND  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_ENSET = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_ENCLR = 6'h28;

  // Per-bit action vector of a write-one register: zero unless this offset is hit
  function automatic logic [VEC_W-1:0] w1_strobe(input logic we,
                                                 input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] off,
                                                 input logic [VEC_W-1:0] d);
    return (we && (a == off)) ? (d & LIVE_BITS) : '0;
  endfunction

  function automatic logic any_active(input logic [VEC_W-1:0] pend,
                                      input logic [VEC_W-1:0] en);
    return |(pend & en & LIVE_BITS);
  endfunction

  function automatic logic [VEC_W-1:0] mask_view(input logic [VEC_W-1:0] en);
    return ~en & LIVE_BITS;
  endfunction
endpackage

// File: rtl/irqbank_cell.sv
module irqbank_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic clr,
  input  logic en_set,
  input  logic en_clr,
  output logic pend,
  output logic en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      en   <= 1'b0;
    end else begin
      // an arriving event outranks a software clear in the same cycle
      pend <= ev | (pend & ~clr);
      if (en_set)      en <= 1'b1;
      else if (en_clr) en <= 1'b0;
    end
  end
endmodule

// File: rtl/irqbank_rdmux.sv
module irqbank_rdmux
  import irqbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [VEC_W-1:0]  pend,
  input  logic [VEC_W-1:0]  en,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    case (addr)
      OFF_PEND: rdata[VEC_W-1:0] = pend & LIVE_BITS;
      OFF_MASK: rdata[VEC_W-1:0] = mask_view(en);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
  import irqbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  event_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  logic [VEC_W-1:0] wvec;
  logic [VEC_W-1:0] ev_vec;
  logic [VEC_W-1:0] clr_vec;
  logic [VEC_W-1:0] set_vec;
  logic [VEC_W-1:0] dis_vec;
  logic [VEC_W-1:0] pend_q;
  logic [VEC_W-1:0] en_q;

  assign wvec    = wdata[VEC_W-1:0];
  assign ev_vec  = event_i & LIVE_BITS;
  assign clr_vec = w1_strobe(wr_en, addr, OFF_PEND,  wvec);
  assign set_vec = w1_strobe(wr_en, addr, OFF_ENSET, wvec);
  assign dis_vec = w1_strobe(wr_en, addr, OFF_ENCLR, wvec);

  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    if (LIVE_BITS[i]) begin : g_live
      irqbank_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_vec[i]),
        .clr    (clr_vec[i]),
        .en_set (set_vec[i]),
        .en_clr (dis_vec[i]),
        .pend   (pend_q[i]),
        .en     (en_q[i])
      );
    end else begin : g_rsvd
      assign pend_q[i] = 1'b0;
      assign en_q[i]   = 1'b0;
    end
  end

  irqbank_rdmux #(.DATA_W(DATA_W)) u_rd (
    .addr  (addr),
    .pend  (pend_q),
    .en    (en_q),
    .rdata (rdata)
  );

  assign irq_o = any_active(pend_q, en_q);
endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk
  import irqbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [VEC_W-1:0]  event_i,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [VEC_W-1:0]  wvec,
  input logic [VEC_W-1:0]  pend_q,
  input logic [VEC_W-1:0]  en_q,
  input logic              irq_o
);
  p_event_latches_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(event_i) & LIVE_BITS) == ($past(event_i) & LIVE_BITS)));

  p_clear_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_PEND && event_i == '0) |=> ((pend_q & $past(wvec)) == '0));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && event_i == '0) |=> $stable(pend_q));

  p_set_enables_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_ENSET) |=> ((en_q & $past(wvec) & LIVE_BITS) == ($past(wvec) & LIVE_BITS)));

  p_disable_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_ENCLR && ((wvec & LIVE_BITS) == LIVE_BITS)) |=> !irq_o);

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q | en_q) & ~LIVE_BITS) == '0);
endmodule

bind irqbank_top irqbank_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .event_i (event_i),
  .wr_en   (wr_en),
  .addr    (addr),
  .wvec    (wvec),
  .pend_q  (pend_q),
  .en_q    (en_q),
  .irq_o   (irq_o)
);

// File: tb/tb_irqbank_top.sv
module tb_irqbank_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  event_i = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int m_pend = 0;
  int m_en   = 0;
  localparam int LIVE = 'h0F7;

  always #5 clk = ~clk;

  irqbank_top dut (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    if (a == 'h10) return m_pend;
    if (a == 'h20) return (~m_en) & LIVE;
    return 0;
  endfunction

  // drive one cycle, compare outputs before the edge, then advance the model
  task automatic step(input string tag, input int ev, input bit we, input int a, input int d);
    @(negedge clk);
    event_i = ev[9:0];
    wr_en   = we;
    addr    = a[5:0];
    wdata   = d;
    #1;
    chk({tag, " rdata"}, rdata, model_read(a));
    chk({tag, " irq"}, {31'b0, irq_o}, {31'b0, (m_pend & m_en) != 0});
    @(posedge clk);
    begin
      int clr;
      clr = (we && a == 'h10) ? d : 0;
      m_pend = (ev | (m_pend & ~clr)) & LIVE;
      if (we && a == 'h24) m_en = m_en | (d & LIVE);
      if (we && a == 'h28) m_en = m_en & ~d;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    addr = 6'h20;
    #1;
    chk("R9 reset mask", rdata, 32'h0F7);
    chk("R9 reset irq", {31'b0, irq_o}, 32'h0);
    addr = 6'h10;
    #1;
    chk("R9 reset pending", rdata, 32'h0);
    rst_n = 1'b1;

    step("R1 all events, sources disabled", 'h3FF, 0, 'h10, 0);
    step("R10 reserved positions stay clear", 0, 0, 'h10, 0);
    step("R8 pending but disabled keeps irq low", 0, 1, 'h10, 0);
    step("R2 zero write leaves pending", 0, 1, 'h10, 'h001);
    step("R2 bit0 cleared", 0, 0, 'h10, 0);
    step("R4 enable all incl reserved", 0, 1, 'h24, 'hFFFF_FFFF);
    step("R7 enable reads zero", 0, 0, 'h24, 0);
    step("R6 mask shows enabled", 0, 0, 'h20, 0);
    step("R6 write mask ignored", 0, 1, 'h20, 'h3FF);
    step("R7 disable reads zero", 0, 1, 'h28, 0);
    step("R5 zero disable no effect", 0, 0, 'h20, 0);
    step("R3 event wins over clear", 'h004, 1, 'h10, 'h004);
    step("R3 bit2 still pending", 0, 0, 'h10, 0);
    step("R5 disable bits 1,2,4-7", 0, 1, 'h28, 'h0F6);
    step("R8 irq off after disable", 0, 0, 'h20, 0);
    step("R8 clear remaining", 0, 1, 'h10, 'h3FF);
    step("R1 event while enabled bit0", 0, 0, 'h10, 0);
    step("R1 new event", 'h001, 0, 'h10, 0);
    step("R8 irq rises from pending and enabled", 0, 0, 'h00, 0);
    step("R7 unmapped offset", 0, 1, 'h2C, 'hFFFF_FFFF);

    for (int n = 0; n < 400; n++) begin
      int ev, a, d, k;
      bit we;
      ev = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 1023)) : 0;
      k  = $urandom_range(0, 5);
      a  = (k == 0) ? 'h10 : (k == 1) ? 'h20 : (k == 2) ? 'h24 :
           (k == 3) ? 'h28 : (k == 4) ? 'h00 : 'h2C;
      d  = int'($urandom);
      we = $urandom_range(0, 2) == 0;
      step("R8 random mix", ev, we, a, d);
    end

    @(negedge clk);
    wr_en = 1'b0;
    event_i = '0;
    finish_run();
  end
endmodule